// File: doc/BRIEF.md
# Configurable Routing Switch Box

This block is the point where a horizontal and a vertical routing channel cross in a grid of logic blocks. It has four sides: left, top, right and bottom. Each side carries `W` single-bit tracks. Every track has an input into the box and an output out of it, so any track can act as a source or as a destination. Each output track is fed by a one-hot selector. The selector chooses among the three tracks on the other sides that the topology allows to reach it, and it can also choose none of them. Routing through the box is purely combinational.

The selector bits sit in a serial configuration chain. The chain shifts one bit per cycle while the shift input is high, and its last bit leaves on `cfg_dout` so that boxes can be chained together. While loading is in progress, and until a load-done strobe arrives, every output is held at 0. The `TOPO` parameter chooses which track pairs can be joined: planar, where only tracks with the same index connect, or a Wilton-style arrangement, where tracks change index at the turns. If the configuration enables two or more sources onto one output, that output is forced to 0 and a contention flag is raised.

Top module: `sbox_switch`

## Requirements
- R1: After reset the chain is all zero, the box is unloaded, `trk_out` is 0, `conflict` is 0 and `cfg_dout` is 0.
- R2: At each rising edge where `cfg_shift` is 1, chain bit 0 takes `cfg_din` and bit k takes the old bit k-1. `cfg_dout` always shows bit 12*W-1, the last bit. Chain bit (d*W+t)*3+k enables, for the output on side d, track t, the source on side (d+1+k) mod 4. Sides are numbered 0 left, 1 top, 2 right, 3 bottom. Track t of side s occupies bit s*W+t of `trk_in` and of `trk_out`.
- R3: A rising edge with `cfg_shift` high unloads the box. A rising edge with `cfg_done` high and `cfg_shift` low loads it. When both are high, shifting wins. While the box is unloaded, `trk_out` is 0 and `conflict` is 0.
- R4: With `TOPO` planar, an output on track t takes its enabled source from track t of that source side.
- R5: With `TOPO` Wilton, track t on one side connects to other sides as follows. Left–right and top–bottom keep index t. Left–top and right–bottom map t to (W-t) mod W in both directions. A left output takes bottom track (t+1) mod W, and a bottom output takes left track (t+W-1) mod W. A top output takes right track (t+1) mod W, and a right output takes top track (t+W-1) mod W.
- R6: In a loaded box, an output whose three enable bits are all 0 drives 0.
- R7: In a loaded box, an output with two or more enable bits set drives 0 and sets `conflict` to 1. `conflict` is 0 whenever no output has more than one enable set.
- R8: While `cfg_shift` is low, the chain contents do not change, whatever `cfg_din` and `cfg_done` do, so the routing stays as it was.
- R9: In a loaded box, an output with exactly one enable follows the selected input track in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_shift | input | 1 | Shift the configuration chain one place |
| cfg_din | input | 1 | Serial configuration bit entering chain bit 0 |
| cfg_done | input | 1 | Load-done strobe that enables the routing |
| cfg_dout | output | 1 | Last chain bit, for the next box in the chain |
| trk_in | input | 4*W | Track inputs, side-major (side*W+track) |
| trk_out | output | 4*W | Track outputs, side-major (side*W+track) |
| conflict | output | 1 | Two or more sources enabled onto one output track |

## Verification
The assertions check four things on every cycle: outputs stay silent after a shift and while the box is unloaded, a track with contention always drives 0, `cfg_dout` stays stable when no shift occurs, and the box loads only after a done strobe that arrives without a shift. Only the bench scenarios can show that the Wilton and planar index maps are correct, that the serial bit order places each enable where the layout says it goes, and that stray `cfg_din` and `cfg_done` activity leaves the routing unchanged. For this reason the bench drives both topologies with the same stimulus and compares them against its own map.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    typedef enum logic {
        TOPO_PLANAR = 1'b0,
        TOPO_WILTON = 1'b1
    } topo_e;

    localparam int SIDES = 4;
    localparam int FANIN = SIDES - 1;

    // Index of the track on side src that may join track t on side dst.
    function automatic int partner(topo_e topo, int dst, int src, int t, int w);
        if (topo == TOPO_PLANAR) return t;
        if (((dst + src) % 2) == 0) return t;                  // opposite sides
        if ((dst == 0 && src == 1) || (dst == 1 && src == 0) ||
            (dst == 2 && src == 3) || (dst == 3 && src == 2))
            return (w - t) % w;                                // mirrored turn
        if ((dst == 0 && src == 3) || (dst == 1 && src == 2))
            return (t + 1) % w;                                // rotate forward
        return (t + w - 1) % w;                                // rotate back
    endfunction

endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
    parameter int N = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    input  logic         done,
    output logic [N-1:0] bits,
    output logic         active,
    output logic         dout
);
    typedef struct packed {
        logic [N-1:0] chain;
        logic         live;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift) begin
            st_d.chain = {st_q.chain[N-2:0], din};
            st_d.live  = 1'b0;
        end else if (done) begin
            st_d.live  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits   = st_q.chain;
    assign active = st_q.live;
    assign dout   = st_q.chain[N-1];

endmodule

// File: rtl/sbox_track_mux.sv
module sbox_track_mux #(
    parameter int FANIN = 3
) (
    input  logic [FANIN-1:0] en,
    input  logic [FANIN-1:0] src,
    input  logic             active,
    output logic             out,
    output logic             clash
);
    localparam int CW = $clog2(FANIN + 1);

    logic [CW-1:0] n_en;

    always_comb begin
        n_en  = CW'($countones(en));
        out   = active && (n_en == CW'(1)) && (|(en & src));
        clash = active && (n_en > CW'(1));
    end

endmodule

// File: rtl/sbox_switch.sv
module sbox_switch #(
    parameter int              W    = 4,
    parameter sbox_pkg::topo_e TOPO = sbox_pkg::TOPO_WILTON
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_shift,
    input  logic           cfg_din,
    input  logic           cfg_done,
    output logic           cfg_dout,
    input  logic [4*W-1:0] trk_in,
    output logic [4*W-1:0] trk_out,
    output logic           conflict
);
    localparam int SIDES  = sbox_pkg::SIDES;
    localparam int FANIN  = sbox_pkg::FANIN;
    localparam int NTRK   = SIDES * W;
    localparam int NBITS  = NTRK * FANIN;

    logic [NBITS-1:0] cfg_bits;
    logic             cfg_active;
    logic [NTRK-1:0]  trk_conflict;

    sbox_cfg_chain #(.N(NBITS)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (cfg_shift),
        .din    (cfg_din),
        .done   (cfg_done),
        .bits   (cfg_bits),
        .active (cfg_active),
        .dout   (cfg_dout)
    );

    for (genvar d = 0; d < SIDES; d++) begin : g_side
        for (genvar t = 0; t < W; t++) begin : g_trk
            localparam int OUT_IX = d * W + t;
            logic [FANIN-1:0] src_v;

            for (genvar k = 0; k < FANIN; k++) begin : g_src
                localparam int S_SIDE = (d + 1 + k) % SIDES;
                localparam int S_TRK  = sbox_pkg::partner(TOPO, d, S_SIDE, t, W);
                assign src_v[k] = trk_in[S_SIDE * W + S_TRK];
            end

            sbox_track_mux #(.FANIN(FANIN)) u_mux (
                .en     (cfg_bits[OUT_IX*FANIN +: FANIN]),
                .src    (src_v),
                .active (cfg_active),
                .out    (trk_out[OUT_IX]),
                .clash  (trk_conflict[OUT_IX])
            );
        end
    end

    assign conflict = |trk_conflict;

endmodule

// File: rtl/sbox_switch_chk.sv
module sbox_switch_chk #(
    parameter int W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_shift,
    input logic           cfg_done,
    input logic           cfg_dout,
    input logic [4*W-1:0] trk_out,
    input logic           conflict,
    input logic           cfg_active,
    input logic [4*W-1:0] trk_conflict
);
    AST_SHIFT_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (trk_out == '0 && !conflict)) else $error("shift did not mute"); // R3

    AST_IDLE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |-> (trk_out == '0 && !conflict)) else $error("unloaded box drives"); // R3

    AST_LOAD_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_active) |-> $past(cfg_done && !cfg_shift)) else $error("load without done"); // R3

    AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> $stable(cfg_dout)) else $error("chain moved without shift"); // R8

    for (genvar k = 0; k < 4*W; k++) begin : g_trk
        AST_CONFLICT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            trk_conflict[k] |-> !trk_out[k]) else $error("contended track drives"); // R7
    end

endmodule

bind sbox_switch sbox_switch_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_shift    (cfg_shift),
    .cfg_done     (cfg_done),
    .cfg_dout     (cfg_dout),
    .trk_out      (trk_out),
    .conflict     (conflict),
    .cfg_active   (cfg_active),
    .trk_conflict (trk_conflict)
);

// File: tb/sbox_switch_bench.sv
module sbox_switch_bench;
    localparam int W          = 4;
    localparam int NT         = 4 * W;
    localparam int N          = 12 * W;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_shift = 1'b0, cfg_din = 1'b0, cfg_done = 1'b0;
    logic [NT-1:0] trk_in = '0;
    logic          dout_w, dout_p, conf_w, conf_p;
    logic [NT-1:0] out_w, out_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbox_switch #(.W(W), .TOPO(sbox_pkg::TOPO_WILTON)) u_sbox_switch (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .cfg_done(cfg_done), .cfg_dout(dout_w), .trk_in(trk_in),
        .trk_out(out_w), .conflict(conf_w));

    sbox_switch #(.W(W), .TOPO(sbox_pkg::TOPO_PLANAR)) u_sbox_switch_planar (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .cfg_done(cfg_done), .cfg_dout(dout_p), .trk_in(trk_in),
        .trk_out(out_p), .conflict(conf_p));

    typedef struct {
        logic [NT-1:0] ew;
        logic [NT-1:0] ep;
        logic          cw;
        logic          cp;
        string         tag;
    } exp_t;

    exp_t     sb_q[$];
    int       n_checks = 0;
    int       n_fail   = 0;
    bit       finished = 1'b0;
    logic [N-1:0] cur_cfg = '0;
    bit       live = 1'b0;

    // Track on side src that joins track t of side dst (bench's own table).
    function automatic int pmap(bit wil, int dst, int src, int t);
        if (!wil) return t;
        case ({dst[1:0], src[1:0]})
            4'b00_10, 4'b10_00, 4'b01_11, 4'b11_01: return t;
            4'b00_01, 4'b01_00, 4'b10_11, 4'b11_10: return (W - t) % W;
            4'b00_11: return (t + 1) % W;
            4'b11_00: return (t + W - 1) % W;
            4'b01_10: return (t + 1) % W;
            4'b10_01: return (t + W - 1) % W;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [NT:0] model(logic [N-1:0] cfg, logic [NT-1:0] tin, bit wil, bit on);
        logic [NT-1:0] o = '0;
        logic          c = 1'b0;
        if (on) begin
            for (int d = 0; d < 4; d++) begin
                for (int t = 0; t < W; t++) begin
                    int   cnt = 0;
                    logic v   = 1'b0;
                    for (int k = 0; k < 3; k++) begin
                        if (cfg[(d*W + t)*3 + k]) begin
                            int s = (d + 1 + k) % 4;
                            cnt++;
                            v = tin[s*W + pmap(wil, d, s, t)];
                        end
                    end
                    o[d*W + t] = (cnt == 1) ? v : 1'b0;
                    if (cnt > 1) c = 1'b1;
                end
            end
        end
        return {c, o};
    endfunction

    task automatic check(string tag);
        exp_t e;
        logic [NT:0] rw, rp;
        rw = model(cur_cfg, trk_in, 1'b1, live);
        rp = model(cur_cfg, trk_in, 1'b0, live);
        e.ew = rw[NT-1:0]; e.cw = rw[NT];
        e.ep = rp[NT-1:0]; e.cp = rp[NT];
        e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
        #1;
    endtask

    task automatic cmp(string tag, logic [NT:0] act, logic [NT:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expectations and compares against both instances.
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() != 0);
            #1;
            e = sb_q.pop_front();
            cmp({e.tag, " wilton"}, {conf_w, out_w}, {e.cw, e.ew});
            cmp({e.tag, " planar"}, {conf_p, out_p}, {e.cp, e.ep});
        end
    end

    task automatic load(logic [N-1:0] cfg, bit done_on_last, output logic [N-1:0] seen);
        for (int n = N - 1; n >= 0; n--) begin
            @(negedge clk);
            seen[n]   = dout_w;
            cfg_shift = 1'b1;
            cfg_din   = cfg[n];
            cfg_done  = (done_on_last && n == 0);
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_done  = 1'b0;
        cur_cfg   = cfg;
        live      = 1'b0;
    endtask

    task automatic strobe_done();
        @(negedge clk);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        live     = 1'b1;
    endtask

    function automatic logic [N-1:0] make_cfg(int kind);
        logic [N-1:0] c = '0;
        for (int k = 0; k < NT; k++) begin
            case (kind)
                0: c[k*3 + ((k*7 + 1) % 3)] = 1'b1;
                1: begin
                    if (k % 4 == 1) begin
                        c[k*3] = 1'b1; c[k*3 + 2] = 1'b1;
                    end else if (k % 4 != 0) begin
                        c[k*3 + (k % 3)] = 1'b1;
                    end
                end
                default: c[k*3 + ((k + 2) % 3)] = 1'b1;
            endcase
        end
        return c;
    endfunction

    initial begin
        logic [N-1:0] cfg_a, cfg_b, cfg_c, seen;
        cfg_a = make_cfg(0);
        cfg_b = make_cfg(1);
        cfg_c = make_cfg(2);

        repeat (3) @(negedge clk);
        trk_in = '1;
        check("R1 reset outputs quiet");
        n_checks++;
        if (dout_w !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 cfg_dout actual=%b expected=0", dout_w);
        end
        @(negedge clk);
        rst_n = 1'b1;

        load(cfg_a, 1'b0, seen);
        trk_in = 16'hFFFF;
        check("R3 loaded but no done yet");
        strobe_done();
        trk_in = 16'hA5C3; check("R5 R4 R9 single source pattern 1");
        trk_in = 16'h1248; check("R5 R4 R9 single source pattern 2");
        trk_in = 16'h7E01; check("R5 R4 R9 single source pattern 3");
        trk_in = 16'h0000; check("R9 all low");

        load(cfg_b, 1'b0, seen);
        strobe_done();
        trk_in = 16'hFFFF; check("R6 R7 empty and double enables, all high");
        trk_in = 16'h3C96; check("R6 R7 empty and double enables, mixed");

        load(cfg_c, 1'b1, seen);
        n_checks++;
        if (seen !== cfg_b) begin
            n_fail++;
            $display("FAIL R2 shifted-out stream actual=%h expected=%h", seen, cfg_b);
        end
        trk_in = 16'hFFFF;
        check("R3 done together with shift is ignored");
        strobe_done();
        trk_in = 16'hC35A; check("R2 R5 R4 new chain contents");

        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cfg_din  = i[0];
            cfg_done = i[1];
        end
        @(negedge clk);
        cfg_din = 1'b0; cfg_done = 1'b0;
        trk_in = 16'hC35A; check("R8 routing unchanged without shift");
        trk_in = 16'h0FF0; check("R8 R9 routing after stray strobes");

        @(negedge clk);
        cfg_shift = 1'b1; cfg_din = 1'b1;
        @(negedge clk);
        cfg_shift = 1'b0;
        live = 1'b0;
        check("R3 one shift unloads the box");

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule